// File: doc/BRIEF.md
# Read-Sequence Store Trigger Detector

This block watches the asynchronous, active-low control lines and the 13-bit address of an 8K x 8 nonvolatile SRAM. It spots a software store command that is made only of read cycles, so the memory keeps the pin behaviour of a plain SRAM. The key is six reads, in this order: 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F. When the sixth matching read completes, the block sends a one-cycle store request to the nonvolatile sequencer. It then disables the bus I/O until the sequencer reports completion.

The bus lines are first brought into the clock domain through a synchronizer whose depth is a parameter. A monitor turns the sampled lines into end-of-read and end-of-write events. A matcher steps through the key. A small controller owns the request pulse and the I/O-disable flag.

Top module: `nvs_store_trigger`

## Requirements
- R1: After reset, `store_req` and `io_disable` are both 0.
- R2: Six read cycles of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, with nothing in between, produce exactly one `store_req` pulse that is one clock long.
- R3: `io_disable` rises in the same clock as `store_req` and stays 1 until a clock in which `store_done` is 1. It is 0 in the clock after that.
- R4: A write cycle, meaning one with `bus_ce_n`=0 and `bus_we_n`=0, returns the matcher to its idle step. A key that a write breaks therefore produces no request.
- R5: A read whose address is not the next key address returns the matcher to idle. If that address is 0x0000, it counts as the first key step.
- R6: A read cycle means `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1. It is counted once, when `bus_ce_n` or `bus_oe_n` rises to end it. Holding a read for many clocks still counts as one step. Toggling only `bus_oe_n` while `bus_ce_n` stays low ends one read and starts another.
- R7: While `io_disable` is 1, completed reads and writes are ignored and do not change the matcher step.
- R8: A `store_done` pulse while `io_disable` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | SRAM chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | SRAM output enable, active low, asynchronous |
| bus_we_n | input | 1 | SRAM write enable, active low, asynchronous |
| bus_addr | input | 13 | SRAM byte address |
| store_done | input | 1 | Sequencer reports that the store has finished |
| store_req | output | 1 | One-clock request to start a store |
| io_disable | output | 1 | Bus I/O disabled while a store is in progress |

## Verification
The bench builds the block with its default two-stage synchronizer. This is the depth a real asynchronous SRAM bus needs, and it puts the whole path from a control edge to the request pulse under test. Each bus access is held for several clocks. That makes it possible to test that a long read and an output-enable-only toggle each count exactly once. It also gives room to pulse `store_done` in the idle state and to interleave broken, restarted and disabled-period key attempts.

// File: rtl/nvs_key_pkg.sv
package nvs_key_pkg;
    localparam int ADDR_W  = 13;
    localparam int KEY_LEN = 6;
    localparam int STEP_W  = $clog2(KEY_LEN);
    localparam int BUS_W   = ADDR_W + 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam step_t LAST_STEP = step_t'(KEY_LEN - 1);

    typedef struct packed {
        logic  ce_n;
        logic  oe_n;
        logic  we_n;
        addr_t addr;
    } bus_s;

    typedef struct packed {
        logic  rd_end;
        logic  wr_end;
        addr_t addr;
    } access_s;

    function automatic addr_t key_addr(input step_t idx);
        case (idx)
            step_t'(0): key_addr = addr_t'('h0000);
            step_t'(1): key_addr = addr_t'('h1555);
            step_t'(2): key_addr = addr_t'('h0AAA);
            step_t'(3): key_addr = addr_t'('h1FFF);
            step_t'(4): key_addr = addr_t'('h10F0);
            default:    key_addr = addr_t'('h0F0F);
        endcase
    endfunction
endpackage

// File: rtl/nvs_bus_sync.sv
module nvs_bus_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_pass
            assign dout = din;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '1;
                end else begin
                    stg[0] <= din;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign dout = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/nvs_cycle_mon.sv
module nvs_cycle_mon
    import nvs_key_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_s    bus,
    output access_s ev
);
    logic  rd_now, wr_now, prev_rd, prev_wr;
    addr_t held;

    assign rd_now = !bus.ce_n && !bus.oe_n && bus.we_n;
    assign wr_now = !bus.ce_n && !bus.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd <= 1'b0;
            prev_wr <= 1'b0;
            held    <= '0;
        end else begin
            prev_rd <= rd_now;
            prev_wr <= wr_now;
            if (rd_now) held <= bus.addr;
        end
    end

    always_comb begin
        ev.rd_end = prev_rd && (bus.ce_n || bus.oe_n);
        ev.wr_end = prev_wr && !wr_now;
        ev.addr   = held;
    end

    // R6
    rd_once_chk: assert property (@(posedge clk) disable iff (rst)
        ev.rd_end |=> !ev.rd_end);
endmodule

// File: rtl/nvs_key_match.sv
module nvs_key_match
    import nvs_key_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_s ev,
    input  logic    io_off,
    output logic    fire
);
    step_t step, step_n;

    always_comb begin
        step_n = step;
        fire   = 1'b0;
        if (!io_off) begin
            if (ev.wr_end) begin
                step_n = '0;
            end else if (ev.rd_end) begin
                if (ev.addr == key_addr(step)) begin
                    if (step == LAST_STEP) begin
                        fire   = 1'b1;
                        step_n = '0;
                    end else begin
                        step_n = step + step_t'(1);
                    end
                end else if (ev.addr == key_addr('0)) begin
                    step_n = step_t'(1);
                end else begin
                    step_n = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step <= '0;
        else     step <= step_n;
    end

    // R7
    no_fire_off_chk: assert property (@(posedge clk) disable iff (rst)
        io_off |-> !fire);
    // R7
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        io_off |=> $stable(step));
    // R2
    fire_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> ev.rd_end);
endmodule

// File: rtl/nvs_store_ctl.sv
module nvs_store_ctl (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic store_done,
    output logic store_req,
    output logic io_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            store_req <= 1'b0;
            io_off    <= 1'b0;
        end else begin
            store_req <= fire;
            if (fire)            io_off <= 1'b1;
            else if (store_done) io_off <= 1'b0;
        end
    end

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);
    // R3
    off_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_off) |-> store_req);
    // R3
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (io_off && !store_done) |=> io_off);
    // R8
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!io_off && !fire) |=> !io_off);
endmodule

// File: rtl/nvs_store_trigger.sv
module nvs_store_trigger
    import nvs_key_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              store_done,
    output logic              store_req,
    output logic              io_disable
);
    logic [BUS_W-1:0] raw_bus, sync_bus;
    bus_s             bus;
    access_s          ev;
    logic             fire;

    assign raw_bus = {bus_ce_n, bus_oe_n, bus_we_n, bus_addr};
    assign bus     = bus_s'(sync_bus);

    nvs_bus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(raw_bus), .dout(sync_bus));

    nvs_cycle_mon u_mon (
        .clk(clk), .rst(rst), .bus(bus), .ev(ev));

    nvs_key_match u_match (
        .clk(clk), .rst(rst), .ev(ev), .io_off(io_disable), .fire(fire));

    nvs_store_ctl u_ctl (
        .clk(clk), .rst(rst), .fire(fire), .store_done(store_done),
        .store_req(store_req), .io_off(io_disable));
endmodule

// File: tb/nvs_store_trigger_test.sv
module nvs_store_trigger_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic        done = 1'b0;
    logic        store_req, io_disable;
    int          checks = 0, fails = 0;
    int          pulses = 0, run = 0, max_run = 0;

    localparam logic [12:0] K0 = 13'h0000, K1 = 13'h1555, K2 = 13'h0AAA,
                            K3 = 13'h1FFF, K4 = 13'h10F0, K5 = 13'h0F0F;

    always #2.5 clk = ~clk;

    nvs_store_trigger uut (
        .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_oe_n(oe_n),
        .bus_we_n(we_n), .bus_addr(addr), .store_done(done),
        .store_req(store_req), .io_disable(io_disable));

    always @(posedge clk) begin
        if (store_req) begin
            pulses <= pulses + 1;
            run    <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end else begin
            run <= 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [12:0] a, input int hold = 4);
        @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        idle(hold);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(6);
    endtask

    task automatic wr(input logic [12:0] a);
        @(negedge clk); addr = a; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(4);
        we_n = 1'b1; ce_n = 1'b1;
        idle(6);
    endtask

    task automatic tail(input int from);
        if (from <= 1) rd(K1);
        if (from <= 2) rd(K2);
        if (from <= 3) rd(K3);
        if (from <= 4) rd(K4);
        rd(K5);
    endtask

    task automatic finish_store();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
        idle(2);
    endtask

    task automatic t_reset();
        check("R1 store_req", int'(store_req), 0);
        check("R1 io_disable", int'(io_disable), 0);
    endtask

    task automatic t_full_key();
        int p0 = pulses;
        rd(K0); tail(1);
        check("R2 pulse count", pulses - p0, 1);
        check("R2 pulse width", max_run, 1);
        check("R3 io_disable set", int'(io_disable), 1);
        idle(20);
        check("R3 io_disable held", int'(io_disable), 1);
        finish_store();
        check("R3 io_disable cleared", int'(io_disable), 0);
    endtask

    task automatic t_disabled_ignored();
        int p0;
        rd(K0); tail(1);
        p0 = pulses;
        rd(K0); tail(1);
        check("R7 key while disabled", pulses - p0, 0);
        rd(K0); rd(K1); rd(K2); wr(13'h0005);
        finish_store();
        check("R3 release after disabled", int'(io_disable), 0);
        tail(3);
        check("R7 partial key not kept", pulses - p0, 0);
        check("R7 still enabled", int'(io_disable), 0);
    endtask

    task automatic t_write_abort();
        int p0 = pulses;
        rd(K0); rd(K1); rd(K2); wr(K3); tail(3);
        check("R4 write aborts", pulses - p0, 0);
        rd(K0); rd(K1); rd(K2); wr(13'h0AAA); rd(K0); tail(1);
        check("R4 restart after write", pulses - p0, 1);
        finish_store();
    endtask

    task automatic t_wrong_read();
        int p0 = pulses;
        rd(K0); rd(K1); rd(K2); rd(K3); rd(13'h0123); tail(4);
        check("R5 wrong read aborts", pulses - p0, 0);
        rd(K0); rd(K1); rd(K2); rd(K0); tail(1);
        check("R5 zero read restarts", pulses - p0, 1);
        finish_store();
        rd(K0); rd(K0); tail(1);
        check("R5 repeated zero restarts", pulses - p0, 2);
        finish_store();
    endtask

    task automatic t_one_count();
        int p0 = pulses;
        rd(K0, 60); tail(1);
        check("R6 long read counted once", pulses - p0, 1);
        finish_store();
        rd(K0); rd(K1, 40); rd(K1); tail(2);
        check("R6 held key read not doubled", pulses - p0, 1);
        @(negedge clk); we_n = 1'b1; addr = K0; ce_n = 1'b0; oe_n = 1'b0;
        idle(4); oe_n = 1'b1; idle(4);
        addr = K1; oe_n = 1'b0; idle(4); oe_n = 1'b1; idle(4);
        ce_n = 1'b1; idle(6);
        tail(2);
        check("R6 oe-only toggles count", pulses - p0, 2);
        finish_store();
    endtask

    task automatic t_idle_done();
        finish_store();
        check("R8 done while idle", int'(io_disable), 0);
        idle(10);
        check("R8 still idle", int'(io_disable), 0);
        check("R8 no request", int'(store_req), 0);
    endtask

    initial begin
        fork
            begin
                idle(4); rst = 1'b0; idle(4);
                t_reset();
                t_full_key();
                t_disabled_ignored();
                t_write_abort();
                t_wrong_read();
                t_one_count();
                t_idle_done();
            end
            begin
                repeat (100000) @(posedge clk);
                check("watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule